// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a sum-of-products logic array. The array outside the block evaluates the product terms. The cell gets twelve of them, grouped into three sum terms of four terms each. It also gets five control terms: two clock terms, two asynchronous reset terms and one output-enable term. An 8-bit configuration word routes the sum terms to two storage flip-flops or straight to the pin. Each flip-flop can work as a D or a T element.

The pin is driven either from the first flip-flop (registered mode) or straight from the selected sum terms (combinational mode), with a programmable polarity. Three feedback pairs, each in true and complement form, go back to the array. Clock terms are not used as real clocks. The block samples them on one free-running system clock and detects their rising edges, so the whole cell stays synchronous to that clock. Only the two reset terms act asynchronously.

Top module: `pld_macrocell`

## Requirements
- R1: The three sum terms are A = OR of pt[3:0], B = OR of pt[7:4] and C = OR of pt[11:8].
- R2: Configuration fields are: cfg[1:0] fold select, cfg[2] output mode, cfg[3] polarity, cfg[4] FF1 type, cfg[5] FF2 type, cfg[6] FF1 pin-clock gate, cfg[7] FF2 pin-clock gate. When cfg[2]=0, the unpolarised pin value is Q1. FF1 loads A|B|C when cfg[2]=0 and cfg[1:0]=10, and A|B in every other setting, including combinational mode.
- R3: When cfg[2]=1, the unpolarised pin value comes from the sum terms: A|B for fold 00, A for 01 and A|B|C for 10. For fold 11 it is A|B when cfg[5]=1 and A when cfg[5]=0.
- R4: FF2 always takes C as its input. The F2 feedback is that input C when cfg[1:0]=11, and Q2 otherwise.
- R5: With cfg[3]=1, pin_out equals the unpolarised value. With cfg[3]=0, pin_out is its complement.
- R6: A type bit of 0 makes its flip-flop load its input on a clocking edge (D). A type bit of 1 makes it invert when the input is 1 and hold when the input is 0 (T).
- R7: The clock source of flip-flop i is ck_term[i], ANDed with pin_clk when its pin-clock gate bit is 1. A flip-flop changes only on a system-clock edge where the source is 1 and was 0 at the previous edge.
- R8: While ar_term[i] is 1, flip-flop i is 0 at once, without waiting for a clock edge. This overrides reset, preset and clocking.
- R9: When sync_preset is 1 on a clocking edge, the flip-flop becomes 1 whatever its type and input.
- R10: A synchronous active-high rst clears both flip-flops and both edge histories.
- R11: pin_oe equals oe_term. fb_pin is pin_out while oe_term is 1, and pin_in otherwise.
- R12: fb_f2_n, fb_q1_n and fb_pin_n are always the complements of fb_f2, fb_q1 and fb_pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| pt | input | 12 | Evaluated product terms, four per sum term |
| ar_term | input | 2 | Asynchronous reset terms for FF1 (bit 0) and FF2 (bit 1) |
| ck_term | input | 2 | Clock terms for FF1 (bit 0) and FF2 (bit 1) |
| oe_term | input | 1 | Output-enable term |
| pin_clk | input | 1 | Dedicated clock pin used for gating |
| sync_preset | input | 1 | Shared synchronous preset |
| cfg | input | 8 | Configuration word |
| pin_in | input | 1 | Value driven onto the pin from outside |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin driver enable (0 = high impedance) |
| fb_f2 | output | 1 | F2 feedback, true |
| fb_f2_n | output | 1 | F2 feedback, complement |
| fb_q1 | output | 1 | Q1 feedback, true |
| fb_q1_n | output | 1 | Q1 feedback, complement |
| fb_pin | output | 1 | Pin feedback, true |
| fb_pin_n | output | 1 | Pin feedback, complement |

## Verification
The bench builds the cell with the default four product terms per sum term. That gives exactly the twelve-term layout whose field positions R1 fixes. It reaches every fold and mode combination of the 8-bit word, including the fold-11 case where the FF2 type bit also chooses the output width. Random stimulus also covers pin-gated clocks, presets that coincide with T-mode toggles, and reset terms asserted across clocking edges. Directed steps cover power-on reset, high-impedance pin feedback and the reset-over-preset priority.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;
  localparam int NUM_SUMS = 3;
  localparam int NUM_FF   = 2;

  // Bit order follows the configuration word: [7] down to [0]
  typedef struct packed {
    logic       clk2_pin;
    logic       clk1_pin;
    logic       ff2_toggle;
    logic       ff1_toggle;
    logic       pol_high;
    logic       comb_mode;
    logic [1:0] fold;
  } mc_cfg_t;

  localparam logic [1:0] FOLD_PAIR   = 2'b00;
  localparam logic [1:0] FOLD_SINGLE = 2'b01;
  localparam logic [1:0] FOLD_ALL    = 2'b10;
  localparam logic [1:0] FOLD_DIRECT = 2'b11;
endpackage

// File: rtl/mc_sum_steer.sv
module mc_sum_steer
  import pld_mc_pkg::*;
#(
  parameter int TPS = 4,
  localparam int PT_W = NUM_SUMS * TPS
) (
  input  logic [PT_W-1:0]   pt,
  input  mc_cfg_t           cfg,
  output logic [NUM_FF-1:0] d_vec,
  output logic              comb_raw,
  output logic              f2_from_input
);
  logic [NUM_SUMS-1:0] sum;

  for (genvar s = 0; s < NUM_SUMS; s++) begin : g_sum
    assign sum[s] = |pt[s*TPS +: TPS];
  end

  logic pair_or;
  logic all_or;
  assign pair_or = sum[0] | sum[1];
  assign all_or  = pair_or | sum[2];

  always_comb begin
    d_vec[0] = (!cfg.comb_mode && cfg.fold == FOLD_ALL) ? all_or : pair_or;
    d_vec[1] = sum[2];
    unique case (cfg.fold)
      FOLD_PAIR:   comb_raw = pair_or;
      FOLD_SINGLE: comb_raw = sum[0];
      FOLD_ALL:    comb_raw = all_or;
      default:     comb_raw = cfg.ff2_toggle ? pair_or : sum[0];
    endcase
    f2_from_input = (cfg.fold == FOLD_DIRECT);
  end
endmodule

// File: rtl/mc_edge_detect.sv
module mc_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= src;
  end

  assign rise = src & ~prev;
endmodule

// File: rtl/mc_flop.sv
module mc_flop (
  input  logic clk,
  input  logic rst,
  input  logic ar,
  input  logic clk_rise,
  input  logic preset,
  input  logic is_toggle,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or posedge ar) begin
    if (ar)             q <= 1'b0;
    else if (rst)       q <= 1'b0;
    else if (clk_rise) begin
      if (preset)         q <= 1'b1;
      else if (is_toggle) q <= q ^ d;
      else                q <= d;
    end
  end
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import pld_mc_pkg::*;
#(
  parameter int TPS = 4,
  localparam int PT_W = NUM_SUMS * TPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PT_W-1:0]   pt,
  input  logic [NUM_FF-1:0] ar_term,
  input  logic [NUM_FF-1:0] ck_term,
  input  logic              oe_term,
  input  logic              pin_clk,
  input  logic              sync_preset,
  input  logic [7:0]        cfg,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              fb_f2,
  output logic              fb_f2_n,
  output logic              fb_q1,
  output logic              fb_q1_n,
  output logic              fb_pin,
  output logic              fb_pin_n
);
  mc_cfg_t            c;
  logic [NUM_FF-1:0]  d_vec;
  logic [NUM_FF-1:0]  q;
  logic [NUM_FF-1:0]  src;
  logic [NUM_FF-1:0]  rise;
  logic [NUM_FF-1:0]  gate_en;
  logic [NUM_FF-1:0]  t_sel;
  logic               comb_raw;
  logic               f2_from_input;
  logic               raw;

  assign c       = mc_cfg_t'(cfg);
  assign gate_en = {c.clk2_pin, c.clk1_pin};
  assign t_sel   = {c.ff2_toggle, c.ff1_toggle};

  mc_sum_steer #(.TPS(TPS)) u_steer (
    .pt           (pt),
    .cfg          (c),
    .d_vec        (d_vec),
    .comb_raw     (comb_raw),
    .f2_from_input(f2_from_input)
  );

  for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
    assign src[i] = gate_en[i] ? (ck_term[i] & pin_clk) : ck_term[i];

    mc_edge_detect u_edge (
      .clk (clk),
      .rst (rst),
      .src (src[i]),
      .rise(rise[i])
    );

    mc_flop u_ff (
      .clk      (clk),
      .rst      (rst),
      .ar       (ar_term[i]),
      .clk_rise (rise[i]),
      .preset   (sync_preset),
      .is_toggle(t_sel[i]),
      .d        (d_vec[i]),
      .q        (q[i])
    );
  end

  assign raw      = c.comb_mode ? comb_raw : q[0];
  assign pin_out  = c.pol_high ? raw : ~raw;
  assign pin_oe   = oe_term;
  assign fb_pin   = oe_term ? pin_out : pin_in;
  assign fb_pin_n = ~fb_pin;
  assign fb_q1    = q[0];
  assign fb_q1_n  = ~q[0];
  assign fb_f2    = f2_from_input ? d_vec[1] : q[1];
  assign fb_f2_n  = ~fb_f2;
endmodule

// File: rtl/mc_checker.sv
module mc_checker #(
  parameter int PT_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic [PT_W-1:0] pt,
  input logic [1:0]      ar_term,
  input logic [1:0]      ck_term,
  input logic            oe_term,
  input logic            sync_preset,
  input logic [7:0]      cfg,
  input logic            pin_in,
  input logic            pin_out,
  input logic            fb_q1,
  input logic            fb_pin
);
  AST_RST_CLEARS: assert property (@(posedge clk)
    (rst && !ar_term[0]) |=> (!fb_q1 || ar_term[0])); // R10

  AST_AR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ar_term[0] |-> !fb_q1); // R8

  AST_HOLD_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    (!$past(ck_term[0]) && !$past(rst) && !ar_term[0] && !$past(ar_term[0]))
      |-> $stable(fb_q1)); // R7

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (rst)
    (!cfg[6] && $rose(ck_term[0]) && sync_preset && !ar_term[0])
      |=> (fb_q1 || ar_term[0])); // R9

  AST_OE_OFF_PIN: assert property (@(posedge clk) disable iff (rst)
    !oe_term |-> (fb_pin == pin_in)); // R11

  AST_COMB_WIDE: assert property (@(posedge clk) disable iff (rst)
    (cfg[2] && cfg[1:0] == 2'b10 && cfg[3]) |-> (pin_out == |pt)); // R3
endmodule

bind pld_macrocell mc_checker #(.PT_W(PT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pt         (pt),
  .ar_term    (ar_term),
  .ck_term    (ck_term),
  .oe_term    (oe_term),
  .sync_preset(sync_preset),
  .cfg        (cfg),
  .pin_in     (pin_in),
  .pin_out    (pin_out),
  .fb_q1      (fb_q1),
  .fb_pin     (fb_pin)
);

// File: tb/pld_macrocell_test.sv
`timescale 1ns/1ps
module pld_macrocell_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pt = '0;
  logic [1:0]  ar_term = '0;
  logic [1:0]  ck_term = '0;
  logic        oe_term = 1'b0;
  logic        pin_clk = 1'b0;
  logic        sync_preset = 1'b0;
  logic [7:0]  cfg = '0;
  logic        pin_in = 1'b0;
  logic        pin_out, pin_oe, fb_f2, fb_f2_n, fb_q1, fb_q1_n, fb_pin, fb_pin_n;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0] m_q    = '0;
  logic [1:0] m_prev = '0;

  always #10 clk = ~clk;

  pld_macrocell uut (
    .clk(clk), .rst(rst), .pt(pt), .ar_term(ar_term), .ck_term(ck_term),
    .oe_term(oe_term), .pin_clk(pin_clk), .sync_preset(sync_preset),
    .cfg(cfg), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .fb_f2(fb_f2), .fb_f2_n(fb_f2_n), .fb_q1(fb_q1), .fb_q1_n(fb_q1_n),
    .fb_pin(fb_pin), .fb_pin_n(fb_pin_n)
  );

  function automatic logic s_a(input logic [11:0] p); return |p[3:0];  endfunction
  function automatic logic s_b(input logic [11:0] p); return |p[7:4];  endfunction
  function automatic logic s_c(input logic [11:0] p); return |p[11:8]; endfunction

  // R2: FF1 input
  function automatic logic exp_d1(input logic [11:0] p, input logic [7:0] c);
    if (!c[2] && c[1:0] == 2'b10) return s_a(p) | s_b(p) | s_c(p);
    return s_a(p) | s_b(p);
  endfunction

  // R3: combinational output before polarity
  function automatic logic exp_comb(input logic [11:0] p, input logic [7:0] c);
    case (c[1:0])
      2'b00:   return s_a(p) | s_b(p);
      2'b01:   return s_a(p);
      2'b10:   return s_a(p) | s_b(p) | s_c(p);
      default: return c[5] ? (s_a(p) | s_b(p)) : s_a(p);
    endcase
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b (cfg=%h pt=%h)", tag, act, exp, cfg, pt);
    end
  endtask

  task automatic check_outputs();
    logic raw, po, f2, pf;
    raw = cfg[2] ? exp_comb(pt, cfg) : m_q[0];
    po  = cfg[3] ? raw : ~raw;
    f2  = (cfg[1:0] == 2'b11) ? s_c(pt) : m_q[1];
    pf  = oe_term ? po : pin_in;
    check(pin_out, po, cfg[2] ? "R1 R3 R5 pin_out" : "R1 R2 R5 pin_out");
    check(pin_oe, oe_term, "R11 pin_oe");
    check(fb_f2, f2, "R4 fb_f2");
    check(fb_q1, m_q[0], "R6 R7 R8 R9 fb_q1");
    check(fb_pin, pf, "R11 fb_pin");
    check((fb_f2_n ^ fb_f2) & (fb_q1_n ^ fb_q1) & (fb_pin_n ^ fb_pin), 1'b1, "R12 complements");
  endtask

  task automatic step(input logic i_rst, input logic [11:0] i_pt, input logic [1:0] i_ar,
                      input logic [1:0] i_ck, input logic i_oe, input logic i_pclk,
                      input logic i_pst, input logic [7:0] i_cfg, input logic i_pin);
    @(negedge clk);
    rst = i_rst; pt = i_pt; ar_term = i_ar; ck_term = i_ck; oe_term = i_oe;
    pin_clk = i_pclk; sync_preset = i_pst; cfg = i_cfg; pin_in = i_pin;
    #1;
    for (int i = 0; i < 2; i++) if (ar_term[i]) m_q[i] = 1'b0;
    check_outputs();
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      logic src, rise, d;
      src  = cfg[6+i] ? (ck_term[i] & pin_clk) : ck_term[i];
      rise = src & ~m_prev[i];
      d    = (i == 0) ? exp_d1(pt, cfg) : s_c(pt);
      if (ar_term[i])      m_q[i] = 1'b0;
      else if (rst)        m_q[i] = 1'b0;
      else if (rise) begin
        if (sync_preset)   m_q[i] = 1'b1;
        else if (cfg[4+i]) m_q[i] = m_q[i] ^ d;
        else               m_q[i] = d;
      end
      m_prev[i] = rst ? 1'b0 : src;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R10: reset
    step(1, 12'h000, 2'b00, 2'b00, 1, 0, 0, 8'h00, 0);
    step(1, 12'h000, 2'b00, 2'b00, 1, 0, 0, 8'h00, 0);
    step(0, 12'h000, 2'b00, 2'b00, 1, 0, 0, 8'h00, 0);
    check(fb_q1, 1'b0, "R10 q1 after reset");
    check(pin_out, 1'b1, "R10 R5 active-low pin after reset");
    // R6: T mode toggling on FF1, D mode on FF2
    for (int k = 0; k < 4; k++) begin
      step(0, 12'h101, 2'b00, 2'b11, 1, 0, 0, 8'h18, 0);
      step(0, 12'h101, 2'b00, 2'b00, 1, 0, 0, 8'h18, 0);
    end
    // R9: preset overrides T toggle
    step(0, 12'h001, 2'b00, 2'b11, 1, 0, 1, 8'h18, 0);
    step(0, 12'h001, 2'b00, 2'b00, 1, 0, 0, 8'h18, 0);
    check(fb_q1, 1'b1, "R9 preset set q1");
    // R8: reset term beats preset and clock edge
    step(0, 12'h001, 2'b01, 2'b01, 1, 0, 1, 8'h08, 0);
    step(0, 12'h001, 2'b00, 2'b00, 1, 0, 0, 8'h08, 0);
    check(fb_q1, 1'b0, "R8 ar over preset");
    // R7: pin-gated clock, pin_clk low blocks the edge
    step(0, 12'h00F, 2'b00, 2'b01, 1, 0, 0, 8'h48, 0);
    step(0, 12'h00F, 2'b00, 2'b01, 1, 1, 0, 8'h48, 0);
    step(0, 12'h00F, 2'b00, 2'b01, 1, 1, 0, 8'h48, 0);
    // R11: high impedance, pin feedback follows pin_in
    step(0, 12'h000, 2'b00, 2'b00, 0, 0, 0, 8'h0C, 1);
    step(0, 12'h000, 2'b00, 2'b00, 0, 0, 0, 8'h0C, 0);
    // R3: fold 11 width chosen by FF2 type
    step(0, 12'h010, 2'b00, 2'b00, 1, 0, 0, 8'h2F, 0);
    step(0, 12'h010, 2'b00, 2'b00, 1, 0, 0, 8'h0F, 0);
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] rc;
      rc = 8'($urandom);
      step(($urandom % 64) == 0, 12'($urandom) & 12'($urandom), {($urandom % 16) == 0, ($urandom % 16) == 0},
           2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0, rc, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule